// File: doc/BRIEF.md
# Redundant-Weight SAR Conversion Sequencer

This block runs the digital side of a successive-approximation converter whose capacitor DAC uses redundant, non-binary weights. It idles after an active-low reset. A rising edge on the start input launches one conversion. The sequencer then walks a list of weights, from largest to smallest. For each weight it puts a trial code on the DAC selects and pulses a strobe to the comparator. It then waits for the comparator to signal ready with a decision before it moves on. Each step therefore advances on a comparator event, not on a fixed count of clock cycles.

The decisions on the four smallest weights are noisy, so they can be repeated an odd number of times. A majority vote over the repeats gives the kept decision, and the DAC code does not change between repeats. The kept weights are summed into a 12-bit binary result, which is saturated at full scale. A completion flag then rises. Because the weights are redundant, a wrong "drop" decision on a large weight can be made up by the smaller weights that follow it.

Top module: `nbSarSequencer`

## Requirements
- R1: Reset state: `convDone` is 0, `result` is 0, `cmpStrobe` is 0 and `dacSel` is all zeros. The block stays idle until it sees a rising edge on `startIn`.
- R2: A 0-to-1 transition of `startIn`, sampled while idle, launches exactly one conversion. Holding `startIn` high afterwards, or toggling it during a conversion, launches nothing further.
- R3: Each comparison raises `cmpStrobe` for exactly one clock. While the strobe is high, `dacSel` equals the kept bits of earlier steps plus the trial bit of the current step, where bit k belongs to step k and step 0 has the largest weight. `dacSel` then holds still until `cmpReady` is seen.
- R4: A final decision of 1 (`cmpDecision` high) keeps the current step's bit in `dacSel` for the rest of the conversion. A final decision of 0 clears it.
- R5: Steps 0 to 9 take one comparison each. Steps 10 to 13 take 1, 3, 7, 15 or 31 comparisons for `avgSel` codes 0, 1, 2, 3 and 4. Codes 5 to 7 act as code 4. `avgSel` is captured when the start edge is accepted.
- R6: On an averaged step, the final decision is 1 exactly when more than half of its comparisons returned 1.
- R7: `result` is the sum of the kept weights, clipped to 4095. The default weights for steps 0 to 13 are 1830, 1000, 560, 310, 176, 96, 56, 32, 18, 10, 6, 4, 2, 1. Each weight is at most one more than the sum of all the weights after it. So for an input no larger than the sum of the later weights, a wrong 0 at one step still ends at the exact input value.
- R8: `convDone` and the new `result` appear in the clock after the last `cmpReady` is sampled. `convDone` stays high until the next accepted start edge, which clears it at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Conversion request; its rising edge is used |
| avgSel | input | 3 | Repeat count code for the four smallest weights |
| cmpReady | input | 1 | Comparator result valid, one-cycle pulse |
| cmpDecision | input | 1 | Comparator decision: 1 keeps the trial bit |
| cmpStrobe | output | 1 | Request one comparison |
| dacSel | output | 14 | Capacitor select per step: kept bits plus current trial bit |
| result | output | 12 | Saturated binary conversion result |
| convDone | output | 1 | Conversion complete flag |

## Verification
Some rules are checked on every clock by the assertions:
- the strobe lasts a single cycle;
- the step index and repeat counter stay inside their bounds and hold still while a decision is pending;
- kept DAC bits never disappear in the middle of a conversion;
- the completion flag rises only on the final commit and then holds.

The other behaviours only the bench's scenarios can show:
- that the majority vote over scripted noisy repeats gives the right result;
- that a deliberately wrong early decision is recovered;
- that the result clips at full scale;
- that repeat codes above the top code are clamped;
- that a start held high, or pulsed during a conversion, launches nothing extra.

// File: rtl/nb_sar_seq_pkg.sv
package nb_sar_seq_pkg;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic clearAll;  // accepted start: wipe kept bits, accumulator, done
    logic commit;    // final decision for the current step is available
    logic decision;  // value of that final decision
    logic finish;    // this commit is the last step of the conversion
  } seqCmd_t;

  // Number of comparisons for a repeat code, clamped at maxSel.
  function automatic int unsigned repsFor(input int unsigned sel, input int unsigned maxSel);
    int unsigned s;
    s = (sel > maxSel) ? maxSel : sel;
    return (2 << s) - 1;
  endfunction

endpackage

// File: rtl/nb_sar_seq_ctrl.sv
module nbSarSeqCtrl
  import nb_sar_seq_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 14,
  parameter int unsigned AVG_STEPS = 4,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned MAX_SEL   = 4,
  localparam int unsigned STEP_W   = $clog2(NUM_STEPS),
  localparam int unsigned MAX_REPS = (2 << MAX_SEL) - 1,
  localparam int unsigned REP_W    = $clog2(MAX_REPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [SEL_W-1:0]  avgSel,
  input  logic              cmpReady,
  input  logic              cmpDecision,
  output logic              cmpStrobe,
  output logic [STEP_W-1:0] stepIdx,
  output logic              busy,
  output seqCmd_t           cmd
);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_WAIT} seqState_t;

  localparam int unsigned FIRST_AVG = NUM_STEPS - AVG_STEPS;
  localparam int unsigned LAST_STEP = NUM_STEPS - 1;

  seqState_t        state, stateNext;
  logic             startPrev;
  logic             startEdge;
  logic [REP_W-1:0] repCnt, repCntNext;
  logic [REP_W-1:0] onesCnt, onesCntNext;
  logic [REP_W-1:0] repTotal, repTotalNext;
  logic [STEP_W-1:0] stepNext;
  logic             inAvgStep;
  logic             lastRepeat;
  logic [REP_W:0]   onesWithNew;

  assign startEdge   = startIn & ~startPrev;
  assign inAvgStep   = (int'(stepIdx) >= FIRST_AVG);
  assign lastRepeat  = !inAvgStep || (repCnt == repTotal - 1'b1);
  assign onesWithNew = {1'b0, onesCnt} + {{REP_W{1'b0}}, cmpDecision};

  always_comb begin
    stateNext    = state;
    stepNext     = stepIdx;
    repCntNext   = repCnt;
    onesCntNext  = onesCnt;
    repTotalNext = repTotal;
    cmd          = '0;
    unique case (state)
      S_IDLE: begin
        if (startEdge) begin
          cmd.clearAll = 1'b1;
          stateNext    = S_STROBE;
          stepNext     = '0;
          repCntNext   = '0;
          onesCntNext  = '0;
          repTotalNext = REP_W'(repsFor(int'(avgSel), MAX_SEL));
        end
      end
      S_STROBE: stateNext = S_WAIT;
      S_WAIT: begin
        if (cmpReady) begin
          if (!lastRepeat) begin
            repCntNext  = repCnt + 1'b1;
            onesCntNext = onesWithNew[REP_W-1:0];
            stateNext   = S_STROBE;
          end else begin
            cmd.commit   = 1'b1;
            cmd.decision = inAvgStep ? (onesWithNew > ({1'b0, repTotal} >> 1)) : cmpDecision;
            repCntNext   = '0;
            onesCntNext  = '0;
            if (int'(stepIdx) == LAST_STEP) begin
              cmd.finish = 1'b1;
              stateNext  = S_IDLE;
            end else begin
              stepNext  = stepIdx + 1'b1;
              stateNext = S_STROBE;
            end
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      startPrev <= 1'b0;
      stepIdx   <= '0;
      repCnt    <= '0;
      onesCnt   <= '0;
      repTotal  <= REP_W'(1);
    end else begin
      state     <= stateNext;
      startPrev <= startIn;
      stepIdx   <= stepNext;
      repCnt    <= repCntNext;
      onesCnt   <= onesCntNext;
      repTotal  <= repTotalNext;
    end
  end

  assign cmpStrobe = (state == S_STROBE);
  assign busy      = (state != S_IDLE);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> !cmpStrobe);

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !cmpReady) |=> $stable(stepIdx));

  // R5
  rep_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (repCnt < repTotal));

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepIdx != '0) |=> (stepIdx != '0 || !busy || $past(cmd.commit)));

endmodule

// File: rtl/nb_sar_seq_data.sv
module nbSarSeqData
  import nb_sar_seq_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 14,
  parameter int unsigned RES_W     = 12,
  parameter int unsigned STEP_WEIGHTS [NUM_STEPS] = '{1830, 1000, 560, 310, 176, 96, 56, 32, 18, 10, 6, 4, 2, 1},
  localparam int unsigned STEP_W   = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              busy,
  output logic [NUM_STEPS-1:0] dacSel,
  output logic [RES_W-1:0]  result,
  output logic              convDone
);

  function automatic int unsigned weightTotal();
    int unsigned t;
    t = 0;
    for (int i = 0; i < NUM_STEPS; i++) t += STEP_WEIGHTS[i];
    return t;
  endfunction

  localparam int unsigned TOTAL   = weightTotal();
  localparam int unsigned ACC_W   = $clog2(TOTAL + 1);
  localparam int unsigned FULL    = (1 << RES_W) - 1;

  logic [NUM_STEPS-1:0] keptBits;
  logic [ACC_W-1:0]     acc;
  logic [ACC_W-1:0]     curWeight;
  logic [ACC_W-1:0]     accNext;

  always_comb begin
    curWeight = '0;
    for (int i = 0; i < NUM_STEPS; i++)
      if (int'(stepIdx) == i) curWeight = ACC_W'(STEP_WEIGHTS[i]);
  end

  assign accNext = (cmd.commit && cmd.decision) ? acc + curWeight : acc;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_sel
    assign dacSel[g] = keptBits[g] | (busy && int'(stepIdx) == g);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keptBits <= '0;
      acc      <= '0;
      result   <= '0;
      convDone <= 1'b0;
    end else if (cmd.clearAll) begin
      keptBits <= '0;
      acc      <= '0;
      convDone <= 1'b0;
    end else if (cmd.commit) begin
      acc <= accNext;
      if (cmd.decision) keptBits[stepIdx] <= 1'b1;
      if (cmd.finish) begin
        convDone <= 1'b1;
        result   <= (int'(accNext) > FULL) ? RES_W'(FULL) : RES_W'(accNext);
      end
    end
  end

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !cmd.clearAll) |=> convDone);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convDone) |-> $past(cmd.finish));

  // R4
  kept_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.clearAll |=> ((keptBits & $past(keptBits)) == $past(keptBits)));

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> !busy);

endmodule

// File: rtl/nb_sar_sequencer.sv
module nbSarSequencer
  import nb_sar_seq_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 14,
  parameter int unsigned AVG_STEPS = 4,
  parameter int unsigned RES_W     = 12,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned MAX_SEL   = 4,
  parameter int unsigned STEP_WEIGHTS [NUM_STEPS] = '{1830, 1000, 560, 310, 176, 96, 56, 32, 18, 10, 6, 4, 2, 1},
  localparam int unsigned STEP_W   = $clog2(NUM_STEPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [SEL_W-1:0]     avgSel,
  input  logic                 cmpReady,
  input  logic                 cmpDecision,
  output logic                 cmpStrobe,
  output logic [NUM_STEPS-1:0] dacSel,
  output logic [RES_W-1:0]     result,
  output logic                 convDone
);

  seqCmd_t           cmd;
  logic [STEP_W-1:0] stepIdx;
  logic              busy;

  nbSarSeqCtrl #(
    .NUM_STEPS(NUM_STEPS), .AVG_STEPS(AVG_STEPS), .SEL_W(SEL_W), .MAX_SEL(MAX_SEL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .avgSel(avgSel),
    .cmpReady(cmpReady), .cmpDecision(cmpDecision),
    .cmpStrobe(cmpStrobe), .stepIdx(stepIdx), .busy(busy), .cmd(cmd)
  );

  nbSarSeqData #(
    .NUM_STEPS(NUM_STEPS), .RES_W(RES_W), .STEP_WEIGHTS(STEP_WEIGHTS)
  ) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stepIdx(stepIdx), .busy(busy),
    .dacSel(dacSel), .result(result), .convDone(convDone)
  );

endmodule

// File: tb/tb_nbSarSequencer.sv
module tb_nbSarSequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [2:0]  avgSel = 3'd0;
  logic        cmpReady = 1'b0;
  logic        cmpDecision = 1'b0;
  logic        cmpStrobe;
  logic [13:0] dacSel;
  logic [11:0] result;
  logic        convDone;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit active = 1'b0;
  bit finished = 1'b0;

  int unsigned W [14] = '{1830, 1000, 560, 310, 176, 96, 56, 32, 18, 10, 6, 4, 2, 1};

  always #4 clk = ~clk;

  nbSarSequencer dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .avgSel(avgSel),
    .cmpReady(cmpReady), .cmpDecision(cmpDecision),
    .cmpStrobe(cmpStrobe), .dacSel(dacSel), .result(result), .convDone(convDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock monitor: no strobe outside a launched conversion (R2)
  always @(negedge clk) begin
    cycles++;
    if (rstN && !finished) begin
      if (!active && cmpStrobe) check(1'b0, "R2 stray strobe", 1, 0);
      if (active && convDone && cmpStrobe) check(1'b0, "R8 done during conversion", 1, 0);
    end
    if (cycles > 150000 && !finished) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runConv(input int vin, input int sel, input int flipMask,
                         input int errStep, input int delay, input int midStart,
                         input bit holdStart, input int expectExact);
    int s, reps, acc, strobes, expRes;
    logic [13:0] bits;
    s = (sel > 4) ? 4 : sel;
    reps = (2 << s) - 1;
    acc = 0; bits = '0; strobes = 0;
    @(negedge clk);
    avgSel = 3'(sel);
    startIn = 1'b1;
    active = 1'b1;
    @(negedge clk);
    check(convDone == 1'b0, "R8 done cleared by start", int'(convDone), 0);
    if (!holdStart) startIn = 1'b0;
    avgSel = 3'd0;  // captured already (R5)
    for (int k = 0; k < 14; k++) begin
      int n, ones, dec;
      n = (k >= 10) ? reps : 1;
      ones = 0;
      for (int r = 0; r < n; r++) begin
        int d, guard;
        guard = 0;
        while (!cmpStrobe && guard < 1000) begin @(negedge clk); guard++; end
        check(cmpStrobe == 1'b1, "R3 strobe arrives", int'(cmpStrobe), 1);
        strobes++;
        check(dacSel == (bits | 14'(1 << k)), "R3 trial code", int'(dacSel), int'(bits | 14'(1 << k)));
        d = (vin >= acc + int'(W[k])) ? 1 : 0;
        if (k == errStep) d = 0;
        if (k >= 10) d = d ^ ((flipMask >> r) & 1);
        @(negedge clk);
        if (midStart == k && r == 0) begin
          startIn = 1'b1; @(negedge clk); startIn = 1'b0;
        end
        repeat (delay) @(negedge clk);
        check(cmpStrobe == 1'b0 && dacSel == (bits | 14'(1 << k)), "R3 code stable while waiting",
              int'(dacSel), int'(bits | 14'(1 << k)));
        cmpReady = 1'b1; cmpDecision = d[0];
        @(negedge clk);
        cmpReady = 1'b0; cmpDecision = 1'b0;
        ones += d;
      end
      dec = (k >= 10) ? ((2 * ones > n) ? 1 : 0) : ones;  // R6
      if (dec != 0) begin acc += int'(W[k]); bits[k] = 1'b1; end
    end
    expRes = (acc > 4095) ? 4095 : acc;
    check(convDone == 1'b1, "R8 done after last decision", int'(convDone), 1);
    check(int'(result) == expRes, "R7 result", int'(result), expRes);
    check(dacSel == bits, "R4 kept bits", int'(dacSel), int'(bits));
    check(strobes == 10 + 4 * reps, "R5 comparison count", strobes, 10 + 4 * reps);
    if (expectExact >= 0) check(int'(result) == expectExact, "R7 redundancy recovery", int'(result), expectExact);
    active = 1'b0;
    repeat (20) @(negedge clk);
    check(convDone == 1'b1 && cmpStrobe == 1'b0, "R8 done holds", int'(convDone), 1);
    startIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(convDone == 1'b0 && result == 12'd0 && cmpStrobe == 1'b0 && dacSel == 14'd0,
          "R1 reset state", int'(result), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(cmpStrobe == 1'b0 && dacSel == 14'd0, "R1 idle without start", int'(dacSel), 0);
    // plain conversion, single comparisons
    runConv(1234, 0, 0, -1, 0, -1, 1'b0, 1234);
    // wrong early drop recovered, 3 repeats (R7)
    runConv(2000, 1, 0, 0, 1, -1, 1'b0, 2000);
    // 2 of 7 flipped: vote keeps true value (R6)
    runConv(3000, 2, 32'b0000011, -1, 0, -1, 1'b0, 3000);
    // 2 of 3 flipped: vote inverts averaged steps (R6)
    runConv(777, 1, 32'b011, -1, 0, -1, 1'b0, -1);
    // exactly 8 of 15 ones flipped (R6)
    runConv(2500, 3, 32'h00FF, -1, 0, -1, 1'b0, -1);
    // saturation (R7)
    runConv(5000, 0, 0, -1, 0, -1, 1'b0, 4095);
    // code above 4 clamps to 31 repeats (R5)
    runConv(0, 7, 0, -1, 1, -1, 1'b0, 0);
    // start pulse in the middle of a conversion ignored (R2)
    runConv(1500, 0, 0, -1, 2, 5, 1'b0, 1500);
    // start held high after launch: one conversion only (R2)
    runConv(4000, 4, 0, -1, 0, -1, 1'b1, 4000);
    repeat (30) @(negedge clk);
    check(convDone == 1'b1 && cmpStrobe == 1'b0, "R2 held start no relaunch", int'(cmpStrobe), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule